// File: doc/BRIEF.md
# FIFO Slot Bandwidth Allocator

This block manages a display FIFO that is split into eight equal slots shared by five fixed channels. A client asks it to allocate a channel for a pixel rate and a burst length. The block turns the rate into a power-of-two slot count, using a supplied per-slot rate. It then finds the lowest free contiguous run of slots. Finally it writes that channel's 8-bit configuration byte into one of two 32-bit register images, which the FIFO datapath decodes. A release request frees a channel and packs every surviving holder again from slot 0, in channel order. A third request kind computes the channel's end-of-transfer control bit from a line width, using a multi-cycle restoring divider.

Requests use a valid/busy handshake. A request is taken when `req_valid` is high and `busy` is low. `busy` stays high until a one-cycle `resp_valid` pulse, which carries `resp_err`. The controller is a single state machine with six states:
- IDLE accepts a request.
- FLUSH clears the channel's own slots.
- REPACK re-places one channel per cycle, in channel order 0 to 4.
- PLACE performs the new allocation.
- DIVIDE waits for the divider.
- REPLY issues the response.

The transitions are:
- IDLE→REPLY for a rejected request, a release of an empty channel, or a release of a channel holding nothing.
- IDLE→FLUSH for an allocate or release of a channel that holds slots.
- IDLE→PLACE for an allocate of an empty channel.
- IDLE→DIVIDE for an end-of-transfer request.
- FLUSH→REPACK.
- REPACK→REPACK while channels remain.
- REPACK→PLACE after the last channel of an allocate.
- REPACK→REPLY after the last channel of a release.
- PLACE→REPLY.
- DIVIDE→REPLY when the quotient is ready.
- REPLY→IDLE.

Top module: `fifo_slot_alloc`

## Requirements
- R1: After reset, `cfg_wr` and `cfg_dp` read 0, `eot_flags` reads 0, `busy` and `resp_valid` are low, and no channel holds slots.
- R2: The slot count is the smallest of 1, 2, 4, 8 whose product with `slot_rate` is at least `req_rate`. A rate above 8×`slot_rate` makes the allocate fail with `resp_err`, and the channel is left holding nothing.
- R3: A placement takes the lowest start slot whose run of the needed length fits inside slots 0..7 and overlaps no held slot. If no such run exists, the allocate fails with `resp_err` and the channel holds nothing. Held runs never overlap.
- R4: Channel 0 first tries twice the computed count and keeps it when a run is free; otherwise it falls back to the computed count. Every other channel gets at least 2 slots.
- R5: A channel byte is: start slot in bits 2:0; size code in bits 4:3 (1, 2, 4, 8 slots map to 3, 2, 1, 0); bit 5 zero; burst code in bits 7:6 (burst 128, 64, 32, 16 map to 0, 1, 2, 3, any other value to 0). The bytes are placed as follows:
  - channel 0 in `cfg_dp[7:0]`
  - channel 2 in `cfg_dp[15:8]`
  - channel 1 in `cfg_dp[23:16]`
  - channel 4 in `cfg_dp[31:24]`
  - channel 3 in `cfg_wr[7:0]`

  A write leaves all other bits unchanged.
- R6: An allocate or release of a channel holding slots first frees it. The remaining holders are then given new start slots by first-fit, in order 0 to 4 from an empty pool, and their bytes are rewritten. The freed channel's own byte is not rewritten by the release.
- R7: `busy` rises only on an accepted request and stays high until `resp_valid`. `resp_valid` is a one-cycle pulse followed by `busy` low. A `req_valid` seen while busy is ignored.
- R8: Counting the accepting clock edge as edge 1, `resp_valid` is visible after edge:
  - 1 for a rejected request or a release of a channel holding nothing
  - 2 for an allocate of an empty channel
  - 7 for a release of a holder
  - 8 for an allocate of a holder
  - 14 for an end-of-transfer request
- R9: `req_op`=2 sets the channel's `eot_flags` bit when (slots×256)/`req_width` exceeds the channel's line limit (3, 1, 2, 2, 1 for channels 0..4), and clears it otherwise. A width of 0 gives `resp_err` and leaves the bit unchanged.
- R10: `req_op` is 0 for allocate, 1 for release and 2 for end-of-transfer. Op code 3, or a channel index of 5 or more, gives `resp_err` and changes no output besides the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 allocate, 1 release, 2 end-of-transfer |
| req_ch | input | 3 | Channel index 0..4 |
| req_rate | input | RATE_W | Requested pixel rate |
| req_burst | input | 8 | Burst length in bytes |
| req_width | input | LINE_W | Line width for end-of-transfer |
| slot_rate | input | RATE_W | Rate carried by one slot |
| busy | output | 1 | Request in progress; new requests stalled |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Request failed, valid with resp_valid |
| cfg_wr | output | 32 | Register image holding channel 3 |
| cfg_dp | output | 32 | Register image holding channels 0, 1, 2, 4 |
| eot_flags | output | 5 | End-of-transfer bit per channel |

## Verification
Each request kind has a fixed latency: 1, 2, 7, 8 or 14 edges, as listed in R8. The bench computes the due edge from the channel's holding state before it drives the request. It counts falling edges until `resp_valid` appears and checks that count against the due edge. Only then does it compare `resp_err`, both register images and `eot_flags` with its model. One falling edge later it confirms that the pulse has ended and `busy` has dropped.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

    localparam int NUM_CH    = 5;
    localparam int NUM_SLOTS = 8;
    localparam int BG_CH     = 0;

    typedef enum logic [1:0] {
        OP_ALLOC   = 2'd0,
        OP_RELEASE = 2'd1,
        OP_EOT     = 2'd2,
        OP_BAD     = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FLUSH,
        S_REPACK,
        S_PLACE,
        S_DIVIDE,
        S_REPLY
    } state_e;

    // channel byte lives in cfg_dp unless it is channel 3
    function automatic logic ch_in_dp(input int ch);
        return ch != 3;
    endfunction

    function automatic int ch_offset(input int ch);
        case (ch)
            1:       return 16;
            2:       return 8;
            4:       return 24;
            default: return 0;
        endcase
    endfunction

    function automatic int ch_line_limit(input int ch);
        case (ch)
            0:       return 3;
            2, 3:    return 2;
            default: return 1;
        endcase
    endfunction

    function automatic logic [1:0] burst_code(input logic [7:0] len);
        case (len)
            8'd16:   return 2'd3;
            8'd32:   return 2'd2;
            8'd64:   return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/fsa_first_fit.sv
module fsa_first_fit #(
    parameter int NSLOT = 8,
    parameter int CNT_W = 5,
    parameter int SEG_W = 3
) (
    input  logic [NSLOT-1:0] used,
    input  logic [CNT_W-1:0] need,
    output logic             found,
    output logic [SEG_W-1:0] seg
);
    localparam int WIDE = 4 * NSLOT;

    logic [WIDE-1:0] span;

    // scan downward so the lowest fitting start slot is the last one kept
    always_comb begin
        found = 1'b0;
        seg   = '0;
        span  = '0;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            span = ((WIDE'(1) << need) - WIDE'(1)) << s;
            if (need != '0 && (s + int'(need)) <= NSLOT &&
                (span[NSLOT-1:0] & used) == '0) begin
                found = 1'b1;
                seg   = SEG_W'(s);
            end
        end
    end
endmodule

// File: rtl/fsa_restoring_div.sv
module fsa_restoring_div #(
    parameter int NUM_W = 12,
    parameter int DEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int CW = $clog2(NUM_W + 1);

    logic             run_q;
    logic             done_q;
    logic [CW-1:0]    cnt_q;
    logic [DEN_W:0]   rem_q;
    logic [NUM_W-1:0] q_q;
    logic [DEN_W-1:0] den_q;
    logic [DEN_W:0]   shifted;
    logic             fits;

    always_comb begin
        shifted = {rem_q[DEN_W-1:0], q_q[NUM_W-1]};
        fits    = shifted >= {1'b0, den_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            rem_q  <= '0;
            q_q    <= '0;
            den_q  <= '0;
        end else if (start) begin
            run_q  <= 1'b1;
            done_q <= 1'b0;
            cnt_q  <= CW'(NUM_W);
            rem_q  <= '0;
            q_q    <= num;
            den_q  <= den;
        end else if (run_q) begin
            rem_q <= fits ? shifted - {1'b0, den_q} : shifted;
            q_q   <= {q_q[NUM_W-2:0], fits};
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
                run_q  <= 1'b0;
                done_q <= 1'b1;
            end
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done = done_q;
    assign quo  = q_q;

    // R9: a finished division leaves a remainder below the divisor
    assert_remainder_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (rem_q < {1'b0, den_q}));
endmodule

// File: rtl/fifo_slot_alloc.sv
module fifo_slot_alloc
    import fsa_pkg::*;
#(
    parameter int RATE_W     = 32,
    parameter int LINE_W     = 12,
    parameter int SLOT_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [2:0]        req_ch,
    input  logic [RATE_W-1:0] req_rate,
    input  logic [7:0]        req_burst,
    input  logic [LINE_W-1:0] req_width,
    input  logic [RATE_W-1:0] slot_rate,
    output logic              busy,
    output logic              resp_valid,
    output logic              resp_err,
    output logic [31:0]       cfg_wr,
    output logic [31:0]       cfg_dp,
    output logic [4:0]        eot_flags
);
    localparam int CNT_W = $clog2(2 * NUM_SLOTS + 1);
    localparam int SEG_W = $clog2(NUM_SLOTS);
    localparam int CH_W  = 3;
    localparam int LOG_S = $clog2(NUM_SLOTS);
    localparam int NUM_W = $clog2(NUM_SLOTS * SLOT_BYTES + 1);
    localparam int CMP_W = RATE_W + LOG_S + 1;

    state_e state_q, state_d;

    logic [CNT_W-1:0]  cnt_q [NUM_CH];
    logic [SEG_W-1:0]  seg_q [NUM_CH];
    logic [1:0]        bc_q  [NUM_CH];
    logic [31:0]       cfg_wr_q, cfg_dp_q;
    logic [NUM_CH-1:0] eot_q;
    op_e               op_q;
    logic [CH_W-1:0]   ch_q, idx_q;
    logic [RATE_W-1:0] rate_q;
    logic [1:0]        bc_req_q;
    logic              err_q;

    logic              req_bad, req_hold, div_start, div_done;
    logic [NUM_W-1:0]  div_quo;
    logic [NUM_SLOTS-1:0] used;
    logic [CNT_W-1:0]  need_cnt, try_cnt, fa_need, sel_cnt;
    logic              too_big, fa_found, fb_found, place_ok;
    logic [SEG_W-1:0]  fa_seg, fb_seg, sel_seg;
    logic              wr_en;
    logic [CH_W-1:0]   wr_ch;
    logic [7:0]        wr_byte;
    logic [CNT_W+2:0]  held_total;

    function automatic logic [1:0] size_code(input logic [CNT_W-1:0] c);
        case (c)
            CNT_W'(1): return 2'd3;
            CNT_W'(2): return 2'd2;
            CNT_W'(4): return 2'd1;
            default:   return 2'd0;
        endcase
    endfunction

    function automatic logic [7:0] mk_byte(input logic [1:0] bc,
                                           input logic [CNT_W-1:0] c,
                                           input logic [SEG_W-1:0] s);
        return {bc, 1'b0, size_code(c), s};
    endfunction

    function automatic logic [NUM_SLOTS-1:0] run_mask(input logic [CNT_W-1:0] c,
                                                      input logic [SEG_W-1:0] s);
        logic [4*NUM_SLOTS-1:0] w;
        w = ((4*NUM_SLOTS)'(1) << c) - (4*NUM_SLOTS)'(1);
        w = w << s;
        return w[NUM_SLOTS-1:0];
    endfunction

    // request decode
    always_comb begin
        req_bad  = (int'(req_ch) >= NUM_CH) || (op_e'(req_op) == OP_BAD) ||
                   (op_e'(req_op) == OP_EOT && req_width == '0);
        req_hold = (int'(req_ch) < NUM_CH) && (cnt_q[req_ch] != '0);
        div_start = (state_q == S_IDLE) && req_valid && !req_bad &&
                    (op_e'(req_op) == OP_EOT);
    end

    // occupancy: during REPACK only channels already re-placed count
    always_comb begin
        used       = '0;
        held_total = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            held_total = held_total + (CNT_W+3)'(cnt_q[i]);
            if (cnt_q[i] != '0 && (state_q != S_REPACK || i < int'(idx_q)))
                used = used | run_mask(cnt_q[i], seg_q[i]);
        end
    end

    // rate to power-of-two slot count
    always_comb begin
        need_cnt = '0;
        too_big  = 1'b1;
        for (int k = LOG_S; k >= 0; k--) begin
            if (CMP_W'(rate_q) <= (CMP_W'(slot_rate) << k)) begin
                need_cnt = CNT_W'(1) << k;
                too_big  = 1'b0;
            end
        end
        if (int'(ch_q) == BG_CH) try_cnt = need_cnt << 1;
        else if (need_cnt < CNT_W'(2)) try_cnt = CNT_W'(2);
        else try_cnt = need_cnt;
        fa_need = (state_q == S_REPACK) ? cnt_q[idx_q] : try_cnt;
    end

    fsa_first_fit #(.NSLOT(NUM_SLOTS), .CNT_W(CNT_W), .SEG_W(SEG_W)) u_fit_a (
        .used(used), .need(fa_need), .found(fa_found), .seg(fa_seg));

    fsa_first_fit #(.NSLOT(NUM_SLOTS), .CNT_W(CNT_W), .SEG_W(SEG_W)) u_fit_b (
        .used(used), .need(need_cnt), .found(fb_found), .seg(fb_seg));

    fsa_restoring_div #(.NUM_W(NUM_W), .DEN_W(LINE_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start),
        .num(NUM_W'(32'(cnt_q[req_ch]) * SLOT_BYTES)),
        .den(req_width), .done(div_done), .quo(div_quo));

    // placement choice and the single register-image write port
    always_comb begin
        place_ok = 1'b0;
        sel_cnt  = try_cnt;
        sel_seg  = fa_seg;
        if (!too_big) begin
            if (fa_found) begin
                place_ok = 1'b1;
            end else if (int'(ch_q) == BG_CH && fb_found) begin
                place_ok = 1'b1;
                sel_cnt  = need_cnt;
                sel_seg  = fb_seg;
            end
        end
        wr_en   = 1'b0;
        wr_ch   = idx_q;
        wr_byte = mk_byte(bc_q[idx_q], cnt_q[idx_q], fa_seg);
        if (state_q == S_REPACK && cnt_q[idx_q] != '0 && fa_found)
            wr_en = 1'b1;
        if (state_q == S_PLACE && place_ok) begin
            wr_en   = 1'b1;
            wr_ch   = ch_q;
            wr_byte = mk_byte(bc_req_q, sel_cnt, sel_seg);
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (req_valid) begin
                if (req_bad) state_d = S_REPLY;
                else if (op_e'(req_op) == OP_EOT) state_d = S_DIVIDE;
                else if (req_hold) state_d = S_FLUSH;
                else if (op_e'(req_op) == OP_ALLOC) state_d = S_PLACE;
                else state_d = S_REPLY;
            end
            S_FLUSH:  state_d = S_REPACK;
            S_REPACK: if (int'(idx_q) == NUM_CH - 1)
                          state_d = (op_q == OP_ALLOC) ? S_PLACE : S_REPLY;
            S_PLACE:  state_d = S_REPLY;
            S_DIVIDE: if (div_done) state_d = S_REPLY;
            S_REPLY:  state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                cnt_q[i] <= '0;
                seg_q[i] <= '0;
                bc_q[i]  <= '0;
            end
            cfg_wr_q <= '0;
            cfg_dp_q <= '0;
            eot_q    <= '0;
            op_q     <= OP_ALLOC;
            ch_q     <= '0;
            idx_q    <= '0;
            rate_q   <= '0;
            bc_req_q <= '0;
            err_q    <= 1'b0;
        end else begin
            if (wr_en) begin
                if (ch_in_dp(int'(wr_ch))) cfg_dp_q[ch_offset(int'(wr_ch)) +: 8] <= wr_byte;
                else                       cfg_wr_q[ch_offset(int'(wr_ch)) +: 8] <= wr_byte;
            end
            unique case (state_q)
                S_IDLE: if (req_valid) begin
                    op_q     <= op_e'(req_op);
                    ch_q     <= req_ch;
                    rate_q   <= req_rate;
                    bc_req_q <= burst_code(req_burst);
                    err_q    <= req_bad;
                end
                S_FLUSH: begin
                    cnt_q[ch_q] <= '0;
                    seg_q[ch_q] <= '0;
                    idx_q       <= '0;
                end
                S_REPACK: begin
                    if (cnt_q[idx_q] != '0) begin
                        if (fa_found) seg_q[idx_q] <= fa_seg;
                        else          cnt_q[idx_q] <= '0;
                    end
                    idx_q <= idx_q + CH_W'(1);
                end
                S_PLACE: begin
                    if (place_ok) begin
                        cnt_q[ch_q] <= sel_cnt;
                        seg_q[ch_q] <= sel_seg;
                        bc_q[ch_q]  <= bc_req_q;
                    end else begin
                        err_q <= 1'b1;
                    end
                end
                S_DIVIDE: if (div_done)
                    eot_q[ch_q] <= (int'(div_quo) > ch_line_limit(int'(ch_q)));
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy       = (state_q != S_IDLE);
        resp_valid = (state_q == S_REPLY);
        resp_err   = (state_q == S_REPLY) && err_q;
        cfg_wr     = cfg_wr_q;
        cfg_dp     = cfg_dp_q;
        eot_flags  = eot_q;
    end

    // R3: held runs are disjoint whenever the machine is at rest
    assert_disjoint_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> ($countones(used) == int'(held_total)));

    // R7: busy only rises on a presented request
    assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    // R7: the response is a single pulse and frees the handshake
    assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && !busy));

    // R10: nothing visible changes on the accepting edge
    assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |=> ($stable(cfg_wr) && $stable(cfg_dp) && $stable(eot_flags)));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cnt_chk
        // R2: every held count is a power of two within the pool
        assert_pow2_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == S_IDLE) |->
            ($countones(cnt_q[g]) <= 1 && cnt_q[g] <= CNT_W'(NUM_SLOTS)));
    end
endmodule

// File: tb/fifo_slot_alloc_test.sv
module fifo_slot_alloc_test;
    localparam int NCH = 5;
    localparam int SR  = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [2:0]  req_ch = '0;
    logic [31:0] req_rate = '0;
    logic [7:0]  req_burst = '0;
    logic [11:0] req_width = '0;
    logic [31:0] slot_rate = 32'(SR);
    logic        busy, resp_valid, resp_err;
    logic [31:0] cfg_wr, cfg_dp;
    logic [4:0]  eot_flags;

    int checks = 0;
    int fails  = 0;

    int m_cnt [NCH];
    int m_seg [NCH];
    int m_bc  [NCH];
    bit m_pl  [NCH];
    logic [31:0] m_wr, m_dp;
    logic [4:0]  m_eot;

    always #10 clk = ~clk;

    fifo_slot_alloc uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_ch(req_ch), .req_rate(req_rate), .req_burst(req_burst),
        .req_width(req_width), .slot_rate(slot_rate), .busy(busy),
        .resp_valid(resp_valid), .resp_err(resp_err), .cfg_wr(cfg_wr),
        .cfg_dp(cfg_dp), .eot_flags(eot_flags));

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int fit(input int need);
        int used = 0;
        for (int i = 0; i < NCH; i++)
            if (m_pl[i] && m_cnt[i] > 0) used |= ((1 << m_cnt[i]) - 1) << m_seg[i];
        for (int s = 0; s + need <= 8; s++)
            if (((((1 << need) - 1) << s) & used) == 0) return s;
        return -1;
    endfunction

    task automatic m_write(input int ch);
        int sc, f;
        sc = (m_cnt[ch] == 1) ? 3 : (m_cnt[ch] == 2) ? 2 : (m_cnt[ch] == 4) ? 1 : 0;
        f  = (m_bc[ch] << 6) | (sc << 3) | m_seg[ch];
        case (ch)
            0: m_dp[7:0]   = 8'(f);
            1: m_dp[23:16] = 8'(f);
            2: m_dp[15:8]  = 8'(f);
            3: m_wr[7:0]   = 8'(f);
            default: m_dp[31:24] = 8'(f);
        endcase
    endtask

    task automatic m_release(input int ch);
        int s;
        if (m_cnt[ch] == 0) return;
        m_cnt[ch] = 0;
        m_seg[ch] = 0;
        for (int i = 0; i < NCH; i++) m_pl[i] = 0;
        for (int i = 0; i < NCH; i++) begin
            if (m_cnt[i] > 0) begin
                s = fit(m_cnt[i]);
                if (s < 0) m_cnt[i] = 0;
                else begin m_seg[i] = s; m_pl[i] = 1; m_write(i); end
            end
        end
    endtask

    task automatic m_alloc(input int ch, input int rate, input int burst, output int err);
        int n, s;
        err = 0;
        m_release(ch);
        n = 16;
        for (int k = 8; k >= 1; k = k / 2) if (rate <= k * SR) n = k;
        if (n > 8) begin err = 1; return; end
        if (ch == 0) begin
            s = fit(2 * n);
            if (s >= 0) n = 2 * n; else s = fit(n);
        end else begin
            if (n < 2) n = 2;
            s = fit(n);
        end
        if (s < 0) begin err = 1; return; end
        m_cnt[ch] = n; m_seg[ch] = s; m_pl[ch] = 1;
        m_bc[ch] = (burst == 16) ? 3 : (burst == 32) ? 2 : (burst == 64) ? 1 : 0;
        m_write(ch);
    endtask

    task automatic run(input int op, input int ch, input int rate, input int burst,
                       input int width, input bit poke, input string tag);
        int exp_err, exp_lat, n, lim;
        bit bad;
        exp_err = 0;
        bad = (ch >= NCH) || (op == 3) || (op == 2 && width == 0);
        if (bad) begin
            exp_err = 1; exp_lat = 1;
        end else if (op == 0) begin
            exp_lat = (m_cnt[ch] > 0) ? NCH + 3 : 2;
            m_alloc(ch, rate, burst, exp_err);
        end else if (op == 1) begin
            exp_lat = (m_cnt[ch] > 0) ? NCH + 2 : 1;
            m_release(ch);
        end else begin
            exp_lat = 14;
            lim = (ch == 0) ? 3 : (ch == 2 || ch == 3) ? 2 : 1;
            m_eot[ch] = ((m_cnt[ch] * 256) / width) > lim;
        end
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_ch = 3'(ch);
        req_rate = 32'(rate); req_burst = 8'(burst); req_width = 12'(width);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        if (exp_lat > 1) chk("R7 busy during request", busy, 1);
        if (poke && exp_lat > 2) begin
            req_valid = 1'b1; req_op = 2'd1; req_ch = 3'((ch + 1) % NCH);
        end
        while (!resp_valid && n < 60) begin
            @(negedge clk);
            req_valid = 1'b0;
            n++;
        end
        chk("R8 latency", n, exp_lat);
        chk({tag, " resp_err"}, resp_err, exp_err);
        chk({tag, " cfg_wr"}, cfg_wr, m_wr);
        chk({tag, " cfg_dp"}, cfg_dp, m_dp);
        chk({tag, " eot_flags"}, eot_flags, m_eot);
        @(negedge clk);
        chk("R7 pulse ends", {busy, resp_valid}, 0);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        checks++;
        $display("FAIL R7 watchdog actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] lcg;
        int op, ch, rate, burst, width;
        for (int i = 0; i < NCH; i++) begin
            m_cnt[i] = 0; m_seg[i] = 0; m_bc[i] = 0; m_pl[i] = 0;
        end
        m_wr = '0; m_dp = '0; m_eot = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cfg_wr", cfg_wr, 0);
        chk("R1 cfg_dp", cfg_dp, 0);
        chk("R1 eot_flags", eot_flags, 0);
        chk("R1 busy/resp", {busy, resp_valid}, 0);

        run(0, 3, 150, 64, 0, 0, "R5");       // ch3 two slots at 0 -> 0x50
        chk("R5 ch3 byte", cfg_wr[7:0], 8'h50);
        run(0, 0, 100, 16, 0, 0, "R4");       // ch0 doubled to 2 at slot 2
        chk("R4 ch0 byte", cfg_dp[7:0], 8'hD2);
        run(0, 2, 50, 128, 0, 0, "R4");       // raised to 2 slots at 4
        chk("R4 ch2 byte", cfg_dp[15:8], 8'h14);
        run(0, 1, 300, 32, 0, 0, "R3");      // no run of 4 free
        run(0, 4, 900, 16, 0, 0, "R2");      // too fast
        run(1, 0, 0, 0, 0, 1, "R6");         // release with a stray request while busy
        chk("R6 ch2 repacked", cfg_dp[15:8], 8'h10);
        chk("R6 ch3 repacked", cfg_wr[7:0], 8'h52);
        run(1, 0, 0, 0, 0, 0, "R8");         // release of empty channel
        run(2, 2, 0, 0, 0, 0, "R9");         // width zero
        run(2, 2, 0, 0, 100, 0, "R9");       // 512/100 = 5 > 2
        chk("R9 ch2 bit set", eot_flags[2], 1);
        run(2, 2, 0, 0, 512, 1, "R9");       // 1 not above 2
        chk("R9 ch2 bit clear", eot_flags[2], 0);
        run(0, 6, 100, 16, 0, 0, "R10");
        run(3, 1, 100, 16, 0, 0, "R10");
        run(0, 0, 200, 48, 0, 0, "R4");      // doubled to 4 at slot 4
        chk("R4 ch0 four slots", cfg_dp[7:0], 8'h0C);
        run(0, 3, 400, 16, 0, 1, "R6");      // holder re-allocated

        lcg = 32'h1234_5678;
        for (int it = 0; it < 320; it++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            op = (lcg[20:18] < 3'd4) ? 0 : (lcg[20:18] < 3'd6) ? 1 :
                 (lcg[20:18] == 3'd6) ? 2 : 3;
            ch = int'(lcg[25:23]) % 6;
            rate = int'(lcg[15:6]) % 1000;
            case (lcg[29:28])
                2'd0: burst = 16;
                2'd1: burst = 32;
                2'd2: burst = 64;
                default: burst = lcg[30] ? 128 : 48;
            endcase
            width = int'(lcg[11:2]) % 600;
            run(op, ch, rate, burst, width, lcg[31],
                (op == 0) ? "R3" : (op == 1) ? "R6" : (op == 2) ? "R9" : "R10");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule